// File: doc/BRIEF.md
# Indexed Clock-Divider Register Port

This block is a 32-bit register window, reached through two addresses, into a small bank of clock-generator control registers. Software first writes an index byte, then reads or writes a data word. The index byte holds three things: a 6-bit register number, a write-enable flag, and a divider-select bit that is stored and read back but has no other effect here. A data-port write reaches the selected register only when the write-enable flag in the current index byte is set. A data-port read always returns the selected register.

The bank holds four registers: a reference divider, a combined feedback/post divider, a control register, and a pixel-clock source select. Software writes the divider values into shadow copies. The live divider outputs take the shadow values all at once, through an atomic commit. Software requests a commit with a request bit in the reference-divider register. A busy bit reads 1 while the commit is pending. Four clock cycles after the request, the commit copies the shadows to the live registers and clears both bits. A commit makes progress only while atomic update is enabled in the control register. While the control register's reset bit is set, the live dividers are held at their reset values.

Top module: `clkpll_regport`

## Requirements
- R1: A write to address 0 stores bus_wdata[7:0] as the index byte, and a read of address 0 returns it zero-extended. In the index byte, bits [5:0] are the register number, bit 6 is the write-enable flag, and bit 7 is the divider-select bit, which is kept unchanged.
- R2: A write to address 1 while index bit 6 is 0 changes no register.
- R3: A read of address 1 returns the register selected by index bits [5:0]. The register numbers are: 2 = control, 3 = reference divider, 6 = combined divider, 13 = clock source. Any other number reads as zero.
- R4: A write to register 3 stores bits [9:0] in the reference shadow. A write to register 6 stores bits [10:0] as the feedback shadow and bits [18:16] as the post-divider shadow. A shadow write alone never changes live_ref, live_fb or live_post.
- R5: A write to register 3 with bit 15 set, made while no commit is pending, starts a commit. From the next cycle on, register 3 reads bit 15 (request) and bit 18 (busy) as 1.
- R6: The commit updates live_ref, live_fb and live_post together at the 4th rising edge after the request edge, if atomic update stays enabled and reset stays clear. Bits 15 and 18 read 0 from that edge on.
- R7: Control register bit 16 enables atomic update, bit 0 is the reset bit, and bits 1 and 17 are sleep and a second update enable; all four bits are stored and read back. While bit 16 is 0, a pending commit waits, and it resumes its count once bit 16 is set.
- R8: While control bit 0 is set, each edge loads the live dividers with their reset values (ref 12, feedback 100, post 1) and the commit count is frozen.
- R9: A write to register 13 stores bits [1:0], which drive pclk_src (0 selects the CPU-side clock, 3 selects the PLL output).
- R10: A shadow write in the same cycle as a commit edge does not reach the live outputs: the commit takes the shadow values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | 0 = index byte, 1 = data port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current bus_addr (combinational) |
| live_ref | output | 10 | Live reference divider |
| live_fb | output | 11 | Live feedback divider |
| live_post | output | 3 | Live post-divider code |
| pclk_src | output | 2 | Pixel clock source select |

## Verification
The bench provokes two collisions. The first is a commit edge that coincides with a new shadow write. The bench issues a request, moves the index to the combined divider, and writes that register on exactly the fourth edge after the request. The live outputs must then show the earlier shadow, and the new value must appear only after a second commit. The second collision is the reset bit being raised while a commit is pending: the live values must return to their reset values, and the commit must wait until the bit is cleared. A behavioural model compares every output and the read data on every cycle.

// File: rtl/clkpll_pkg.sv
package clkpll_pkg;

    localparam int IDX_W = 6;

    localparam logic [IDX_W-1:0] IX_CTRL = 6'd2;
    localparam logic [IDX_W-1:0] IX_REF  = 6'd3;
    localparam logic [IDX_W-1:0] IX_DIV  = 6'd6;
    localparam logic [IDX_W-1:0] IX_SRC  = 6'd13;

    localparam int WE_BIT    = 6;
    localparam int DSEL_BIT  = 7;
    localparam int REQ_BIT   = 15;
    localparam int BUSY_BIT  = 18;
    localparam int POST_LSB  = 16;
    localparam int C_RST_BIT = 0;
    localparam int C_SLP_BIT = 1;
    localparam int C_AEN_BIT = 16;
    localparam int C_VEN_BIT = 17;

    typedef struct packed {
        logic hold;
        logic sleep;
        logic aen;
        logic vga_aen;
    } ctrl_t;

endpackage

// File: rtl/clkpll_index.sv
module clkpll_index
    import clkpll_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [7:0]       wdata_i,
    output logic [IDX_W-1:0] sel_o,
    output logic             we_o,
    output logic [7:0]       byte_o
);

    typedef struct packed {
        logic [7:0] ibyte;
    } idx_state_t;

    idx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) s_d.ibyte = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel_o  = s_q.ibyte[IDX_W-1:0];
    assign we_o   = s_q.ibyte[WE_BIT];
    assign byte_o = s_q.ibyte;

    // R1: the whole byte, divider-select bit included, is kept
    assert_index_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (byte_o == $past(wdata_i)));

endmodule

// File: rtl/clkpll_bank.sv
module clkpll_bank
    import clkpll_pkg::*;
#(
    parameter int REF_W  = 10,
    parameter int FB_W   = 11,
    parameter int POST_W = 3,
    parameter int SRC_W  = 2,
    parameter logic [REF_W-1:0]  REF_RST  = 10'd12,
    parameter logic [FB_W-1:0]   FB_RST   = 11'd100,
    parameter logic [POST_W-1:0] POST_RST = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  sel_i,
    input  logic [31:0]       wdata_i,
    input  logic              pend_i,
    output logic [REF_W-1:0]  ref_sh_o,
    output logic [FB_W-1:0]   fb_sh_o,
    output logic [POST_W-1:0] post_sh_o,
    output ctrl_t             ctrl_o,
    output logic [SRC_W-1:0]  src_o,
    output logic              req_o,
    output logic [31:0]       rdata_o
);

    typedef struct packed {
        logic [REF_W-1:0]  ref_sh;
        logic [FB_W-1:0]   fb_sh;
        logic [POST_W-1:0] post_sh;
        ctrl_t             ctrl;
        logic [SRC_W-1:0]  src;
    } bank_state_t;

    bank_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            case (sel_i)
                IX_REF:  s_d.ref_sh = wdata_i[REF_W-1:0];
                IX_DIV: begin
                    s_d.fb_sh   = wdata_i[FB_W-1:0];
                    s_d.post_sh = wdata_i[POST_LSB +: POST_W];
                end
                IX_CTRL: begin
                    s_d.ctrl.hold    = wdata_i[C_RST_BIT];
                    s_d.ctrl.sleep   = wdata_i[C_SLP_BIT];
                    s_d.ctrl.aen     = wdata_i[C_AEN_BIT];
                    s_d.ctrl.vga_aen = wdata_i[C_VEN_BIT];
                end
                IX_SRC:  s_d.src = wdata_i[SRC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ref_sh  <= REF_RST;
            s_q.fb_sh   <= FB_RST;
            s_q.post_sh <= POST_RST;
            s_q.ctrl    <= '0;
            s_q.src     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o = wr_i && (sel_i == IX_REF) && wdata_i[REQ_BIT];

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            IX_REF: begin
                rdata_o[REF_W-1:0] = s_q.ref_sh;
                rdata_o[REQ_BIT]   = pend_i;
                rdata_o[BUSY_BIT]  = pend_i;
            end
            IX_DIV: begin
                rdata_o[FB_W-1:0]          = s_q.fb_sh;
                rdata_o[POST_LSB +: POST_W] = s_q.post_sh;
            end
            IX_CTRL: begin
                rdata_o[C_RST_BIT] = s_q.ctrl.hold;
                rdata_o[C_SLP_BIT] = s_q.ctrl.sleep;
                rdata_o[C_AEN_BIT] = s_q.ctrl.aen;
                rdata_o[C_VEN_BIT] = s_q.ctrl.vga_aen;
            end
            IX_SRC:  rdata_o[SRC_W-1:0] = s_q.src;
            default: rdata_o = '0;
        endcase
    end

    assign ref_sh_o  = s_q.ref_sh;
    assign fb_sh_o   = s_q.fb_sh;
    assign post_sh_o = s_q.post_sh;
    assign ctrl_o    = s_q.ctrl;
    assign src_o     = s_q.src;

    // R9: source select follows a write to its register
    assert_src_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == IX_SRC) |=> (src_o == $past(wdata_i[SRC_W-1:0])));

endmodule

// File: rtl/clkpll_commit.sv
module clkpll_commit #(
    parameter int REF_W  = 10,
    parameter int FB_W   = 11,
    parameter int POST_W = 3,
    parameter int LAT    = 4,
    parameter logic [REF_W-1:0]  REF_RST  = 10'd12,
    parameter logic [FB_W-1:0]   FB_RST   = 11'd100,
    parameter logic [POST_W-1:0] POST_RST = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              aen_i,
    input  logic              hold_i,
    input  logic [REF_W-1:0]  ref_sh_i,
    input  logic [FB_W-1:0]   fb_sh_i,
    input  logic [POST_W-1:0] post_sh_i,
    output logic [REF_W-1:0]  live_ref_o,
    output logic [FB_W-1:0]   live_fb_o,
    output logic [POST_W-1:0] live_post_o,
    output logic              pend_o
);

    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LAT - 1);

    typedef struct packed {
        logic              pend;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  lref;
        logic [FB_W-1:0]   lfb;
        logic [POST_W-1:0] lpost;
    } cm_state_t;

    cm_state_t s_d, s_q;
    logic      run;

    always_comb begin
        s_d = s_q;
        run = s_q.pend && aen_i && !hold_i;
        if (hold_i) begin
            s_d.lref  = REF_RST;
            s_d.lfb   = FB_RST;
            s_d.lpost = POST_RST;
        end else if (run && s_q.cnt == LAST) begin
            s_d.lref  = ref_sh_i;
            s_d.lfb   = fb_sh_i;
            s_d.lpost = post_sh_i;
        end
        if (run) begin
            if (s_q.cnt == LAST) begin
                s_d.pend = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (req_i && !s_d.pend) begin
            s_d.pend = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pend  <= 1'b0;
            s_q.cnt   <= '0;
            s_q.lref  <= REF_RST;
            s_q.lfb   <= FB_RST;
            s_q.lpost <= POST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign live_ref_o  = s_q.lref;
    assign live_fb_o   = s_q.lfb;
    assign live_post_o = s_q.lpost;
    assign pend_o      = s_q.pend;

    // R6: the latency count stays inside its window
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CNT_W'(LAT));

    // R5: a fresh request is pending on the next cycle
    assert_req_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !pend_o) |=> pend_o);

    // R7: with atomic update off, live values and the pending flag stay put
    assert_paused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !aen_i && !hold_i) |=>
            (pend_o && $stable(live_ref_o) && $stable(live_fb_o) && $stable(live_post_o)));

    // R8: the reset bit forces reset values on the live outputs
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (live_ref_o == REF_RST && live_fb_o == FB_RST && live_post_o == POST_RST));

endmodule

// File: rtl/clkpll_regport.sv
module clkpll_regport
    import clkpll_pkg::*;
#(
    parameter int REF_W  = 10,
    parameter int FB_W   = 11,
    parameter int POST_W = 3,
    parameter int SRC_W  = 2,
    parameter int LAT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [REF_W-1:0]  live_ref,
    output logic [FB_W-1:0]   live_fb,
    output logic [POST_W-1:0] live_post,
    output logic [SRC_W-1:0]  pclk_src
);

    localparam logic [REF_W-1:0]  REF_RST  = REF_W'(12);
    localparam logic [FB_W-1:0]   FB_RST   = FB_W'(100);
    localparam logic [POST_W-1:0] POST_RST = POST_W'(1);

    logic [IDX_W-1:0]  sel;
    logic              we;
    logic [7:0]        ibyte;
    logic              data_wr;
    logic [REF_W-1:0]  ref_sh;
    logic [FB_W-1:0]   fb_sh;
    logic [POST_W-1:0] post_sh;
    ctrl_t             ctrl;
    logic              req;
    logic              pend;
    logic [31:0]       bank_rdata;

    assign data_wr = bus_wr && bus_addr && we;

    clkpll_index u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (bus_wr && !bus_addr),
        .wdata_i(bus_wdata[7:0]),
        .sel_o  (sel),
        .we_o   (we),
        .byte_o (ibyte)
    );

    clkpll_bank #(
        .REF_W(REF_W), .FB_W(FB_W), .POST_W(POST_W), .SRC_W(SRC_W),
        .REF_RST(REF_RST), .FB_RST(FB_RST), .POST_RST(POST_RST)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (data_wr),
        .sel_i    (sel),
        .wdata_i  (bus_wdata),
        .pend_i   (pend),
        .ref_sh_o (ref_sh),
        .fb_sh_o  (fb_sh),
        .post_sh_o(post_sh),
        .ctrl_o   (ctrl),
        .src_o    (pclk_src),
        .req_o    (req),
        .rdata_o  (bank_rdata)
    );

    clkpll_commit #(
        .REF_W(REF_W), .FB_W(FB_W), .POST_W(POST_W), .LAT(LAT),
        .REF_RST(REF_RST), .FB_RST(FB_RST), .POST_RST(POST_RST)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .aen_i      (ctrl.aen),
        .hold_i     (ctrl.hold),
        .ref_sh_i   (ref_sh),
        .fb_sh_i    (fb_sh),
        .post_sh_i  (post_sh),
        .live_ref_o (live_ref),
        .live_fb_o  (live_fb),
        .live_post_o(live_post),
        .pend_o     (pend)
    );

    assign bus_rdata = bus_addr ? bank_rdata : {24'd0, ibyte};

    // R2: a data write without the enable flag leaves the bank untouched
    assert_we_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !we) |=>
            ($stable(ref_sh) && $stable(fb_sh) && $stable(post_sh) &&
             $stable(ctrl) && $stable(pclk_src)));

    // R4: live outputs move only while a commit is pending or the reset bit is set
    assert_live_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !ctrl.hold) |=> ($stable(live_ref) && $stable(live_fb) && $stable(live_post)));

endmodule

// File: tb/clkpll_regport_tb.sv
module clkpll_regport_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic        b_addr = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic [9:0]  live_ref;
    logic [10:0] live_fb;
    logic [2:0]  live_post;
    logic [1:0]  pclk_src;

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0]  m_idx;
    logic [9:0]  m_ref, m_lref;
    logic [10:0] m_fb, m_lfb;
    logic [2:0]  m_post, m_lpost;
    logic        m_crst, m_slp, m_en, m_ven, m_pend;
    logic [1:0]  m_src;
    int          m_cnt;

    always #5 clk = ~clk;

    clkpll_regport u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .live_ref(live_ref),
        .live_fb(live_fb), .live_post(live_post), .pclk_src(pclk_src)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idx = 8'd0; m_ref = 10'd12; m_fb = 11'd100; m_post = 3'd1;
            m_lref = 10'd12; m_lfb = 11'd100; m_lpost = 3'd1;
            m_crst = 0; m_slp = 0; m_en = 0; m_ven = 0; m_pend = 0;
            m_src = 2'd0; m_cnt = 0;
        end else begin
            bit run;
            run = m_pend && m_en && !m_crst;
            if (m_crst) begin
                m_lref = 10'd12; m_lfb = 11'd100; m_lpost = 3'd1;
            end else if (run && m_cnt == 3) begin
                m_lref = m_ref; m_lfb = m_fb; m_lpost = m_post;
            end
            if (run) begin
                if (m_cnt == 3) begin m_pend = 0; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            if (b_wr && !b_addr) m_idx = b_wdata[7:0];
            else if (b_wr && b_addr && m_idx[6]) begin
                case (m_idx[5:0])
                    6'd2: begin
                        m_crst = b_wdata[0]; m_slp = b_wdata[1];
                        m_en = b_wdata[16]; m_ven = b_wdata[17];
                    end
                    6'd3: begin
                        m_ref = b_wdata[9:0];
                        if (b_wdata[15] && !m_pend) begin m_pend = 1; m_cnt = 0; end
                    end
                    6'd6: begin m_fb = b_wdata[10:0]; m_post = b_wdata[18:16]; end
                    6'd13: m_src = b_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        logic [31:0] r;
        r = '0;
        if (!b_addr) r[7:0] = m_idx;
        else begin
            case (m_idx[5:0])
                6'd2: begin r[0] = m_crst; r[1] = m_slp; r[16] = m_en; r[17] = m_ven; end
                6'd3: begin r[9:0] = m_ref; r[15] = m_pend; r[18] = m_pend; end
                6'd6: begin r[10:0] = m_fb; r[18:16] = m_post; end
                6'd13: r[1:0] = m_src;
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    task automatic compare();
        logic [31:0] er;
        er = exp_rd();
        vectors++;
        if (rdata !== er || live_ref !== m_lref || live_fb !== m_lfb ||
            live_post !== m_lpost || pclk_src !== m_src) begin
            fails++;
            $display("FAIL %s: rdata=%h/%h ref=%0d/%0d fb=%0d/%0d post=%0d/%0d src=%0d/%0d (actual/expected)",
                     cur_req, rdata, er, live_ref, m_lref, live_fb, m_lfb,
                     live_post, m_lpost, pclk_src, m_src);
        end
    endtask

    task automatic step(input logic wr, input logic addr, input logic [31:0] d);
        @(negedge clk);
        compare();
        b_wr = wr; b_addr = addr; b_wdata = d;
    endtask

    task automatic idle(input int n, input logic addr);
        for (int i = 0; i < n; i++) step(1'b0, addr, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R8";               // reset state of live outputs
        idle(2, 1'b0);
        cur_req = "R1";               // index byte incl. divider-select bit 7
        step(1'b1, 1'b0, 32'hFFFF_FF8D);
        idle(2, 1'b0);
        cur_req = "R9";               // source select with write enable
        step(1'b1, 1'b0, 32'h0000_004D);
        step(1'b1, 1'b1, 32'h0000_0003);
        idle(2, 1'b1);
        cur_req = "R3";               // unimplemented index reads zero
        step(1'b1, 1'b0, 32'h0000_0045);
        idle(2, 1'b1);
        cur_req = "R2";               // write with enable flag clear
        step(1'b1, 1'b0, 32'h0000_0006);
        step(1'b1, 1'b1, 32'h0005_0123);
        step(1'b1, 1'b0, 32'h0000_000D);
        step(1'b1, 1'b1, 32'h0000_0000);
        idle(2, 1'b1);
        cur_req = "R4";               // shadow divider writes
        step(1'b1, 1'b0, 32'h0000_0046);
        step(1'b1, 1'b1, 32'h0006_0200);
        idle(3, 1'b1);
        cur_req = "R7";               // request with atomic update disabled
        step(1'b1, 1'b0, 32'h0000_0043);
        step(1'b1, 1'b1, 32'h0000_8021);
        idle(8, 1'b1);
        step(1'b1, 1'b0, 32'h0000_0042);
        step(1'b1, 1'b1, 32'h0003_0002);
        idle(2, 1'b1);
        step(1'b1, 1'b1, 32'h0001_0000);
        cur_req = "R6";               // commit after resume
        idle(6, 1'b1);
        cur_req = "R5";               // new request, busy visible
        step(1'b1, 1'b0, 32'h0000_0046);
        step(1'b1, 1'b1, 32'h0002_0055);
        step(1'b1, 1'b0, 32'h0000_0043);
        step(1'b1, 1'b1, 32'h0000_8033);
        cur_req = "R6";
        idle(6, 1'b1);
        cur_req = "R10";              // shadow write on the commit edge
        step(1'b1, 1'b1, 32'h0000_8044);
        step(1'b1, 1'b0, 32'h0000_0046);
        idle(2, 1'b1);
        step(1'b1, 1'b1, 32'h0007_0077);
        idle(3, 1'b1);
        step(1'b1, 1'b0, 32'h0000_0043);
        step(1'b1, 1'b1, 32'h0000_8044);
        idle(6, 1'b1);
        cur_req = "R8";               // reset bit during a pending commit
        step(1'b1, 1'b1, 32'h0000_8099);
        step(1'b1, 1'b0, 32'h0000_0042);
        step(1'b1, 1'b1, 32'h0001_0001);
        idle(6, 1'b1);
        step(1'b1, 1'b1, 32'h0001_0000);
        idle(7, 1'b1);
        step(1'b1, 1'b0, 32'h0000_0043);
        idle(2, 1'b1);
        @(negedge clk);
        compare();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule